// File: doc/BRIEF.md
# Reset-Loaded Security State Register

This block holds the device security byte. After reset is released it makes one read of a fixed address in nonvolatile memory, waits for the data-valid handshake, and stores the returned byte. If the memory reports an uncorrectable error on that read, the block stores all ones instead. All ones is a secured state with backdoor access turned off.

The stored byte has three fields. Bits 1:0 hold the security code. Bits 7:6 hold the backdoor-enable code. Bits 5:2 are reserved bits that are expected to read as ones and are not decoded.

The block drives two registered status outputs, "secured" and "backdoor enabled". Software can read the byte over a simple bus port but cannot write it. A backdoor-unlock event from the key-comparison logic forces the security code to its open value. That forced state stays in place until the next reset, which reloads the byte from memory.

Top module: `sec_state_reg`

## Requirements
- R1: One cycle after reset deasserts, `mem_req` is high for exactly one cycle, and `mem_addr` equals `SEC_ADDR` (default 23'h7FFF0F). No further request is issued until the next reset.
- R2: On the first cycle in which `mem_rvalid` is high after the request, the byte on `mem_rdata` is stored and `load_done` rises at that same clock edge.
- R3: If `mem_dberr` is high together with that `mem_rvalid`, the stored byte is 8'hFF whatever `mem_rdata` holds.
- R4: While `load_done` is low, `secured` is 1, `bkd_enabled` is 0, and bus reads return 8'hFF.
- R5: Once the load is done, `secured` is 0 only when stored bits 1:0 equal 2'b10. The codes 00, 01 and 11 report secured.
- R6: Once the load is done, `bkd_enabled` is 1 only when stored bits 7:6 equal 2'b10. The codes 00, 01 and 11 report disabled.
- R7: A bus read (`bus_rd` high for one cycle) presents the stored byte on `bus_rdata` one clock later.
- R8: Bus writes (`bus_wr` with any `bus_wdata`) leave the stored byte unchanged.
- R9: An `unlock` pulse while `load_done` is 1 and `bkd_enabled` is 1 sets bits 1:0 to 2'b10 and keeps bits 7:2. From the next cycle `secured` is 0.
- R10: An `unlock` pulse before the load is done, or while backdoor access is disabled, has no effect on the stored byte or the status.
- R11: The forced open state lasts until reset. A new reset reloads the byte from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Single-cycle read request to nonvolatile memory |
| mem_addr | output | ADDR_W | Address of the security byte |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| mem_dberr | input | 1 | Uncorrectable error flag for the read |
| unlock | input | 1 | Backdoor unlock event |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe (ignored) |
| bus_wdata | input | 8 | Write data (ignored) |
| bus_rdata | output | 8 | Registered read data |
| load_done | output | 1 | Byte has been fetched |
| secured | output | 1 | Device secured |
| bkd_enabled | output | 1 | Backdoor key access enabled |

## Verification
The hardest case to reach is the window between the fetch request and the returned data. An unlock pulse or a bus read placed there must be ignored, or must return all ones. To hold that window open for several cycles, the bench's memory responder delays `mem_rvalid` by a programmable latency. Stimulus is then placed inside the window before the byte arrives.

Two other cases also need a fresh reset-and-fetch: an unlock request arriving while the backdoor is disabled, and the uncorrectable-error override. For these the responder returns chosen bytes and a chosen error flag on each reset. The security and backdoor codes are swept through all four values this way.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] OPEN_CODE = 2'b10;
  localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

  typedef enum logic [1:0] {
    FS_ISSUE = 2'd0,
    FS_WAIT  = 2'd1,
    FS_DONE  = 2'd2
  } fetch_st_t;

  function automatic logic code_open(input logic [1:0] code);
    return code == OPEN_CODE;
  endfunction
endpackage

// File: rtl/sec_fetch_seq.sv
module sec_fetch_seq #(
  parameter int ADDR_W = 23,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 23'h7FFF0F
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  output logic              capture
);
  import sec_pkg::*;

  fetch_st_t st_q;
  logic      req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FS_ISSUE;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (st_q)
        FS_ISSUE: begin
          req_q <= 1'b1;
          st_q  <= FS_WAIT;
        end
        FS_WAIT: if (mem_rvalid) st_q <= FS_DONE;
        default: st_q <= FS_DONE;
      endcase
    end
  end

  assign capture  = (st_q == FS_WAIT) && mem_rvalid;
  assign mem_req  = req_q;
  assign mem_addr = SEC_ADDR;

  // R1
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
endmodule

// File: rtl/sec_byte_reg.sv
module sec_byte_reg (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic [sec_pkg::BYTE_W-1:0] mem_rdata,
  input  logic                      mem_dberr,
  input  logic                      unlock,
  output logic [sec_pkg::BYTE_W-1:0] byte_q,
  output logic                      done_q,
  output logic [sec_pkg::BYTE_W-1:0] byte_d,
  output logic                      done_d
);
  import sec_pkg::*;

  logic take_unlock;

  assign take_unlock = done_q && unlock && code_open(byte_q[7:6]);

  always_comb begin
    byte_d = byte_q;
    done_d = done_q;
    if (capture) begin
      byte_d = mem_dberr ? ALL_ONES : mem_rdata;
      done_d = 1'b1;
    end else if (take_unlock) begin
      byte_d[1:0] = OPEN_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= ALL_ONES;
      done_q <= 1'b0;
    end else begin
      byte_q <= byte_d;
      done_q <= done_d;
    end
  end

  // R3
  dberr_override_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && mem_dberr) |=> (byte_q == ALL_ONES));
  // R9
  unlock_force_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && unlock && byte_q[7:6] == 2'b10) |=>
      (byte_q[1:0] == 2'b10 && byte_q[7:2] == $past(byte_q[7:2])));
  // R10
  unlock_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && unlock && byte_q[7:6] != 2'b10) |=> $stable(byte_q));
  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
endmodule

// File: rtl/sec_status_out.sv
module sec_status_out (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [sec_pkg::BYTE_W-1:0] byte_q,
  input  logic                      done_q,
  input  logic [sec_pkg::BYTE_W-1:0] byte_d,
  input  logic                      done_d,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [sec_pkg::BYTE_W-1:0] bus_wdata,
  output logic [sec_pkg::BYTE_W-1:0] bus_rdata,
  output logic                      load_done,
  output logic                      secured,
  output logic                      bkd_enabled
);
  import sec_pkg::*;

  logic unused_wr_ok;
  assign unused_wr_ok = ^{bus_wr, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= ALL_ONES;
      load_done   <= 1'b0;
      secured     <= 1'b1;
      bkd_enabled <= 1'b0;
    end else begin
      load_done   <= done_d;
      secured     <= !(done_d && code_open(byte_d[1:0]));
      bkd_enabled <= done_d && code_open(byte_d[7:6]);
      if (bus_rd) bus_rdata <= done_q ? byte_q : ALL_ONES;
    end
  end

  // R4
  pre_load_status_chk: assert property (@(posedge clk) disable iff (rst)
    !load_done |-> (secured && !bkd_enabled));
  // R4
  pre_load_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !load_done) |=> (bus_rdata == ALL_ONES));
endmodule

// File: rtl/sec_state_reg.sv
module sec_state_reg #(
  parameter int ADDR_W = 23,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 23'h7FFF0F
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_dberr,
  input  logic              unlock,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              load_done,
  output logic              secured,
  output logic              bkd_enabled
);
  import sec_pkg::*;

  logic              capture;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              done_q, done_d;

  sec_fetch_seq #(.ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR)) u_seq (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .capture(capture)
  );

  sec_byte_reg u_reg (
    .clk(clk), .rst(rst), .capture(capture), .mem_rdata(mem_rdata),
    .mem_dberr(mem_dberr), .unlock(unlock), .byte_q(byte_q),
    .done_q(done_q), .byte_d(byte_d), .done_d(done_d)
  );

  sec_status_out u_out (
    .clk(clk), .rst(rst), .byte_q(byte_q), .done_q(done_q),
    .byte_d(byte_d), .done_d(done_d), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_done(load_done),
    .secured(secured), .bkd_enabled(bkd_enabled)
  );

  // R2
  load_rise_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> load_done);
endmodule

// File: tb/sim_sec_state_reg.sv
module sim_sec_state_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [22:0] EXP_ADDR = 23'h7FFF0F;

  logic clk = 0, rst = 1;
  logic mem_req, mem_rvalid = 0, mem_dberr = 0, unlock = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [22:0] mem_addr;
  logic [7:0] mem_rdata = 0, bus_wdata = 0, bus_rdata;
  logic load_done, secured, bkd_enabled;

  int checks = 0, failures = 0, req_cnt = 0, mem_lat = 2;
  logic [7:0] mem_byte = 8'hFF;
  logic mem_err = 0, finished = 0;
  logic [22:0] seen_addr = 0;
  logic [7:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_state_reg u0 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_dberr(mem_dberr),
    .unlock(unlock), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .load_done(load_done), .secured(secured),
    .bkd_enabled(bkd_enabled)
  );

  task automatic check(string req, logic [22:0] act, logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // request counter
  initial forever begin
    @(negedge clk);
    if (!rst && mem_req) begin req_cnt++; seen_addr = mem_addr; end
  end

  // memory responder
  initial forever begin
    @(negedge clk);
    if (!rst && mem_req) begin
      repeat (mem_lat) @(negedge clk);
      mem_rvalid = 1; mem_rdata = mem_byte; mem_dberr = mem_err;
      @(negedge clk);
      mem_rvalid = 0; mem_dberr = 0; mem_rdata = 8'h00;
    end
  end

  // read monitor: scoreboard
  initial forever begin
    logic took;
    @(posedge clk);
    took = bus_rd;
    @(negedge clk);
    if (took) begin
      if (expq.size() == 0) begin
        failures++; checks++;
        $display("FAIL R7 actual=%0h expected=<none>", bus_rdata);
      end else begin
        automatic logic [7:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        check(t, {15'd0, bus_rdata}, {15'd0, e});
      end
    end
  end

  task automatic do_reset(logic [7:0] b, logic err, int lat);
    @(negedge clk);
    rst = 1; mem_byte = b; mem_err = err; mem_lat = lat;
    repeat (3) @(negedge clk);
    req_cnt = 0;
    rst = 0;
  endtask

  task automatic wait_load();
    for (int i = 0; i < 60 && !load_done; i++) @(negedge clk);
  endtask

  task automatic bus_read(logic [7:0] exp, string tag);
    expq.push_back(exp); tagq.push_back(tag);
    bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic pulse_unlock();
    unlock = 1;
    @(negedge clk);
    unlock = 0;
    @(negedge clk);
  endtask

  task automatic load_and_check(logic [7:0] b, logic err, string tag);
    logic [7:0] eb;
    eb = err ? 8'hFF : b;
    do_reset(b, err, 2);
    wait_load();
    check({tag, " R2 done"}, {22'd0, load_done}, 23'd1);
    check({tag, " R5 secured"}, {22'd0, secured}, {22'd0, eb[1:0] != 2'b10});
    check({tag, " R6 bkd"}, {22'd0, bkd_enabled}, {22'd0, eb[7:6] == 2'b10});
    bus_read(eb, {tag, " R7 read"});
  endtask

  initial begin
    // reset state
    @(negedge clk); @(negedge clk);
    check("R4 reset done", {22'd0, load_done}, 23'd0);
    check("R4 reset secured", {22'd0, secured}, 23'd1);
    check("R4 reset bkd", {22'd0, bkd_enabled}, 23'd0);

    // unlock and read inside the fetch window
    do_reset(8'hBF, 0, 8);
    pulse_unlock();
    check("R4 window done", {22'd0, load_done}, 23'd0);
    check("R4 window secured", {22'd0, secured}, 23'd1);
    bus_read(8'hFF, "R4 window read");
    wait_load();
    check("R1 req count", req_cnt, 23'd1);
    check("R1 address", seen_addr, EXP_ADDR);
    check("R10 early unlock secured", {22'd0, secured}, 23'd1);
    check("R6 enabled", {22'd0, bkd_enabled}, 23'd1);
    bus_read(8'hBF, "R10 early unlock read");

    // writes ignored
    bus_wr = 1; bus_wdata = 8'h00;
    @(negedge clk);
    bus_wdata = 8'h5A;
    @(negedge clk);
    bus_wr = 0;
    bus_read(8'hBF, "R8 write ignored");
    check("R8 secured", {22'd0, secured}, 23'd1);

    // honoured unlock
    pulse_unlock();
    check("R9 secured", {22'd0, secured}, 23'd0);
    bus_read(8'hBE, "R9 read");
    repeat (10) @(negedge clk);
    check("R11 persists", {22'd0, secured}, 23'd0);
    check("R1 no extra req", req_cnt, 23'd1);

    // reset reloads
    do_reset(8'hBF, 0, 3);
    wait_load();
    check("R11 reload secured", {22'd0, secured}, 23'd1);
    bus_read(8'hBF, "R11 reload read");

    // unlock with backdoor disabled
    do_reset(8'h7F, 0, 2);
    wait_load();
    pulse_unlock();
    check("R10 disabled unlock", {22'd0, secured}, 23'd1);
    bus_read(8'h7F, "R10 disabled read");

    // uncorrectable fault
    load_and_check(8'hBE, 1, "R3 dberr");
    pulse_unlock();
    check("R3 R10 fault unlock", {22'd0, secured}, 23'd1);

    // code sweeps
    for (int s = 0; s < 4; s++) load_and_check(8'h3C | 8'(s), 0, "R5 sweep");
    for (int k = 0; k < 4; k++) load_and_check(8'(k << 6) | 8'h3F, 0, "R6 sweep");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule